// File: doc/BRIEF.md
# Three-Phase Direct Digital Synthesis Sine Generator

This block is a direct digital synthesis core. It produces three phase-locked sine sample streams for an external three-channel parallel DAC. One 40-bit phase accumulator advances by a programmable frequency word on every clock. Each channel adds a programmable phase shift to the accumulator phase, plus a fixed offset of 0, 1/3 or 2/3 of a turn. The channel keeps the ten most significant bits of that sum as its waveform index. The index addresses a table that holds only one quarter of a sine period, and the full wave is rebuilt by mirroring the address and the sign. The magnitude is then scaled by an amplitude code. The result is presented as a 10-bit offset-binary sample.

A host loads a frequency word, a phase word in tenths of a degree, an amplitude code in 61 levels, and a dither-enable bit. It uses a write port with a strobe and a 2-bit select. The written values wait in shadow registers. A single update strobe makes all of them active together, so the three outputs never show a mixed configuration. Optional phase dithering adds a 16-bit pseudo-random value below the index bits to break up truncation spurs.

Top module: `dds3_sine_gen`

## Requirements
- R1: While reset is asserted and after it is released, the active frequency, phase and amplitude words and the dither bit are zero. Every sample output holds the mid-scale code 512.
- R2: The accumulator adds the active frequency word every clock and wraps modulo 2^40. The waveform index of a channel is bits [39:30] of (accumulator + phase shift + channel offset), taken modulo 2^40.
- R3: The sample is 512 + s, where s is within 3 LSB of 511 · sin(2π·(index+0.5)/1024) · amp/60. Index bit 9 selects the negative half. Index bit 8 selects the mirrored quarter.
- R4: The phase shift is the active phase word times 305419897 (2^40/3600, rounded). A written phase value above 3599 is stored as 3599.
- R5: Channel B adds 366503875925 (⌊2^40/3⌋) and channel C adds 733007751850. Channel A adds nothing. Consecutive channel indices therefore differ by 341 or 342 modulo 1024.
- R6: The magnitude is multiplied by the amplitude code and divided by 60, rounding down. A written amplitude above 60 is stored as 60. Code 0 gives exactly 512 on every channel.
- R7: A write with wr_en high loads a shadow register chosen by wr_sel: 0 = frequency (all 40 bits), 1 = phase (clamped, see R4), 2 = amplitude (clamped, see R6), 3 = control (bit 0 = dither enable). Writes do not change any output until upd is high at a clock edge. That edge copies all shadow values to the active set at once.
- R8: The sample derived from the accumulator value present after clock edge e appears on the outputs after edge e+4. A new phase word taken by upd at edge e first shows after edge e+4.
- R9: With dither enabled, a 16-bit maximal-length LFSR value (never zero) is added to the phase sum below the index bits. Outputs stay within 6 LSB of the undithered value. With dither disabled, no random term is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the shadow registers |
| wr_sel | input | 2 | Shadow register select: 0 frequency, 1 phase, 2 amplitude, 3 control |
| wr_data | input | 40 | Write data |
| upd | input | 1 | Copies all shadow values to the active set |
| samp_a | output | 10 | Offset-binary sample, channel A |
| samp_b | output | 10 | Offset-binary sample, channel B, +120 degrees |
| samp_c | output | 10 | Offset-binary sample, channel C, +240 degrees |

## Verification
Some properties are checked on every cycle inside the design. The active set holds between update strobes. The stored phase and amplitude never exceed their limits. The channel indices keep their 341/342 spacing. A zero amplitude empties the scaled magnitude. The LFSR never locks at zero, and no sample reaches code 0.

Other behaviour can only be shown by the bench's scenarios. These are the actual sine values and the quadrant mirroring, the phase and amplitude clamps seen at the outputs, and the wrap when running backwards. The bench also shows the exact four-cycle latency, the absence of any effect from writes without an update, and the bounded deviation under dither. It does this by comparing every sample against a model of the accumulator and a real-valued sine.

// File: rtl/dds3_pkg.sv
package dds3_pkg;
  localparam int ACC_W    = 40;
  localparam int IDX_W    = 10;
  localparam int QTR_AW   = IDX_W - 2;
  localparam int QTR_N    = 1 << QTR_AW;
  localparam int MAG_W    = IDX_W - 1;
  localparam int FULL_MAG = (1 << MAG_W) - 1;
  localparam int OUT_W    = IDX_W;
  localparam int AMP_W    = 6;
  localparam int AMP_FULL = 60;
  localparam int PH_W     = 12;
  localparam int PH_STEPS = 3600;
  localparam int LFSR_W   = 16;
  localparam int NCH      = 3;
  localparam longint unsigned TURN = 64'd1 << ACC_W;
  localparam logic [ACC_W-1:0] PH_UNIT  = ACC_W'((TURN + PH_STEPS / 2) / PH_STEPS);
  localparam logic [ACC_W-1:0] OFS_STEP = ACC_W'(TURN / NCH);

  typedef enum logic [1:0] {
    SEL_FREQ  = 2'd0,
    SEL_PHASE = 2'd1,
    SEL_AMP   = 2'd2,
    SEL_CTRL  = 2'd3
  } sel_e;

  typedef struct packed {
    logic [ACC_W-1:0] fcw;
    logic [PH_W-1:0]  phase;
    logic [AMP_W-1:0] amp;
    logic             dith_en;
  } ctrl_t;
endpackage

// File: rtl/dds3_regs.sv
module dds3_regs
  import dds3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             upd,
  output ctrl_t            act_o
);
  localparam logic [ACC_W-1:0] PH_MAX  = ACC_W'(PH_STEPS - 1);
  localparam logic [ACC_W-1:0] AMP_MAX = ACC_W'(AMP_FULL);

  ctrl_t sh_q, sh_d, act_q, act_d;

  always_comb begin
    sh_d = sh_q;
    if (wr_en) begin
      case (sel_e'(wr_sel))
        SEL_FREQ:  sh_d.fcw = wr_data;
        SEL_PHASE: sh_d.phase = (wr_data > PH_MAX) ? PH_MAX[PH_W-1:0] : wr_data[PH_W-1:0];
        SEL_AMP:   sh_d.amp = (wr_data > AMP_MAX) ? AMP_MAX[AMP_W-1:0] : wr_data[AMP_W-1:0];
        SEL_CTRL:  sh_d.dith_en = wr_data[0];
        default:   sh_d = sh_q;
      endcase
    end
  end

  always_comb begin
    act_d = act_q;
    if (upd) act_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      sh_q  <= sh_d;
      act_q <= act_d;
    end
  end

  assign act_o = act_q;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> (act_q == $past(act_q)));
  assert_phase_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_q.phase < PH_W'(PH_STEPS));
  assert_amp_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_q.amp <= AMP_W'(AMP_FULL));
endmodule

// File: rtl/dds3_lfsr.sv
module dds3_lfsr
  import dds3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] rnd_o
);
  logic [LFSR_W-1:0] lf_q, lf_d;
  logic              fb;

  always_comb begin
    fb   = lf_q[15] ^ lf_q[13] ^ lf_q[12] ^ lf_q[10];
    lf_d = {lf_q[LFSR_W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lf_q <= LFSR_W'(1);
    else        lf_q <= lf_d;
  end

  assign rnd_o = lf_q;

  assert_lfsr_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lf_q != '0);
endmodule

// File: rtl/dds3_quarter_rom.sv
module dds3_quarter_rom
  import dds3_pkg::*;
(
  input  logic [QTR_AW-1:0] addr_i,
  output logic [MAG_W-1:0]  mag_o
);
  // Entry i holds the sine magnitude at (i + 0.5) / QTR_N of a quarter turn,
  // so mirroring the address by inversion is exactly symmetric.
  function automatic logic [MAG_W-1:0] sine_pt(input int i);
    longint h, p, t, num, den;
    h   = longint'(4 * QTR_N);
    p   = longint'(2 * i + 1);
    t   = p * (h - p);
    num = longint'(FULL_MAG) * 16 * t;
    den = 5 * h * h - 4 * t;
    return MAG_W'((num + den / 2) / den);
  endfunction

  logic [MAG_W-1:0] tbl [QTR_N];

  for (genvar g = 0; g < QTR_N; g++) begin : g_tbl
    assign tbl[g] = sine_pt(g);
  end

  assign mag_o = tbl[addr_i];
endmodule

// File: rtl/dds3_channel.sv
module dds3_channel
  import dds3_pkg::*;
#(
  parameter logic [ACC_W-1:0] CH_OFS = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [ACC_W-1:0] shift_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [OUT_W-1:0] sample_o
);
  localparam int               PROD_W  = MAG_W + AMP_W;
  localparam logic [PROD_W-1:0] DIV    = PROD_W'(AMP_FULL);
  localparam logic [OUT_W-1:0] MID     = OUT_W'(1) << (OUT_W - 1);
  localparam logic [IDX_W-1:0] IDX_RST = CH_OFS[ACC_W-1 -: IDX_W];

  logic [ACC_W-1:0]  sum;
  logic [IDX_W-1:0]  s1_idx_q, s1_idx_d;
  logic [AMP_W-1:0]  s1_amp_q, s2_amp_q;
  logic [QTR_AW-1:0] qaddr;
  logic [MAG_W-1:0]  rom_mag, s2_mag_q, s3_val_q, s3_val_d;
  logic              s2_neg_q, s3_neg_q;
  logic [PROD_W-1:0] prod;
  logic [OUT_W-1:0]  s4_q, s4_d;

  dds3_quarter_rom u_rom (.addr_i(qaddr), .mag_o(rom_mag));

  always_comb begin
    sum      = acc_i + shift_i + CH_OFS;
    s1_idx_d = sum[ACC_W-1 -: IDX_W];
    qaddr    = s1_idx_q[QTR_AW] ? ~s1_idx_q[QTR_AW-1:0] : s1_idx_q[QTR_AW-1:0];
    prod     = PROD_W'(s2_mag_q) * PROD_W'(s2_amp_q);
    s3_val_d = MAG_W'(prod / DIV);
    s4_d     = s3_neg_q ? (MID - OUT_W'(s3_val_q)) : (MID + OUT_W'(s3_val_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_idx_q <= IDX_RST;
      s1_amp_q <= '0;
      s2_mag_q <= '0;
      s2_neg_q <= 1'b0;
      s2_amp_q <= '0;
      s3_val_q <= '0;
      s3_neg_q <= 1'b0;
      s4_q     <= MID;
    end else begin
      s1_idx_q <= s1_idx_d;
      s1_amp_q <= amp_i;
      s2_mag_q <= rom_mag;
      s2_neg_q <= s1_idx_q[IDX_W-1];
      s2_amp_q <= s1_amp_q;
      s3_val_q <= s3_val_d;
      s3_neg_q <= s2_neg_q;
      s4_q     <= s4_d;
    end
  end

  assign idx_o    = s1_idx_q;
  assign sample_o = s4_q;

  assert_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_amp_q == '0) |=> (s3_val_q == '0));
  assert_out_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o != '0);
endmodule

// File: rtl/dds3_sine_gen.sv
module dds3_sine_gen
  import dds3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             upd,
  output logic [OUT_W-1:0] samp_a,
  output logic [OUT_W-1:0] samp_b,
  output logic [OUT_W-1:0] samp_c
);
  localparam logic [IDX_W-1:0] GAP_LO = IDX_W'((1 << IDX_W) / NCH);
  localparam logic [IDX_W-1:0] GAP_HI = GAP_LO + IDX_W'(1);

  ctrl_t             act;
  logic [LFSR_W-1:0] rnd;
  logic [ACC_W-1:0]  acc_q, acc_d, shift;
  logic [IDX_W-1:0]  idx  [NCH];
  logic [OUT_W-1:0]  samp [NCH];

  dds3_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .upd(upd), .act_o(act)
  );

  dds3_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .rnd_o(rnd));

  always_comb begin
    acc_d = acc_q + act.fcw;
    shift = ACC_W'(act.phase) * PH_UNIT + (act.dith_en ? ACC_W'(rnd) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dds3_channel #(.CH_OFS(ACC_W'(OFS_STEP * g))) u_ch (
      .clk(clk), .rst_n(rst_n), .acc_i(acc_q), .shift_i(shift),
      .amp_i(act.amp), .idx_o(idx[g]), .sample_o(samp[g])
    );
  end

  assign samp_a = samp[0];
  assign samp_b = samp[1];
  assign samp_c = samp[2];

  assert_gap_ab_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((IDX_W'(idx[1] - idx[0]) == GAP_LO) || (IDX_W'(idx[1] - idx[0]) == GAP_HI)));
  assert_gap_bc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((IDX_W'(idx[2] - idx[1]) == GAP_LO) || (IDX_W'(idx[2] - idx[1]) == GAP_HI)));
endmodule

// File: tb/tb_dds3_sine_gen.sv
module tb_dds3_sine_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [39:0] wr_data = '0;
  logic        upd = 1'b0;
  logic [9:0]  samp_a, samp_b, samp_c;

  localparam logic [39:0] K_PH   = 40'd305419897;
  localparam logic [39:0] OFS_B  = 40'd366503875925;
  localparam logic [39:0] OFS_C  = 40'd733007751850;
  localparam logic [39:0] F200   = 40'd5497558139;

  dds3_sine_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .upd(upd),
    .samp_a(samp_a), .samp_b(samp_b), .samp_c(samp_c)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  typedef struct {
    real   ea, eb, ec;
    int    amp;
    bit    dith;
    string tag;
  } item_t;
  item_t sb[$];

  logic [39:0] m_acc, s_fcw, a_fcw;
  int          s_ph, a_ph, s_amp, a_amp;
  bit          s_d, a_d;

  function automatic real expect_val(logic [39:0] acc, int ph, logic [39:0] ofs, int amp);
    logic [39:0] s;
    int          idx;
    real         th;
    s   = acc + 40'(ph) * K_PH + ofs;
    idx = int'(s[39:30]);
    th  = 2.0 * 3.14159265358979 * (real'(idx) + 0.5) / 1024.0;
    return 512.0 + 511.0 * $sin(th) * real'(amp) / 60.0;
  endfunction

  task automatic check_val(string tag, string ch, logic [9:0] got, real exp_v, real tol);
    real d;
    checks++;
    d = real'(got) - exp_v;
    if (d < 0.0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s ch %s: got %0d expected %0.2f (tol %0.1f)", tag, ch, got, exp_v, tol);
    end
  endtask

  task automatic check_eq(string tag, int got, int exp_v);
    checks++;
    if (got != exp_v) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp_v);
    end
  endtask

  // Reference model: pushes one expected item per edge (driver side of scoreboard)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = '0; s_fcw = '0; a_fcw = '0;
      s_ph = 0; a_ph = 0; s_amp = 0; a_amp = 0; s_d = 1'b0; a_d = 1'b0;
      sb.delete();
    end else begin
      item_t it;
      it.ea   = expect_val(m_acc, a_ph, 40'd0, a_amp);
      it.eb   = expect_val(m_acc, a_ph, OFS_B, a_amp);
      it.ec   = expect_val(m_acc, a_ph, OFS_C, a_amp);
      it.amp  = a_amp;
      it.dith = a_d;
      it.tag  = cur_req;
      sb.push_back(it);
      m_acc = m_acc + a_fcw;
      if (upd) begin
        a_fcw = s_fcw; a_ph = s_ph; a_amp = s_amp; a_d = s_d;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: s_fcw = wr_data;
          2'd1: s_ph  = (wr_data >= 40'd3599) ? 3599 : int'(wr_data);
          2'd2: s_amp = (wr_data >= 40'd60) ? 60 : int'(wr_data);
          default: s_d = wr_data[0];
        endcase
      end
    end
  end

  // Monitor: the item pushed three edges earlier is visible now (R8 latency)
  always @(negedge clk) begin
    if (rst_n && !done && sb.size() == 4) begin
      item_t it;
      real   tol;
      it  = sb.pop_front();
      tol = (it.amp == 0) ? 0.0 : (it.dith ? 6.0 : 3.0);
      check_val(it.tag, "A", samp_a, it.ea, tol);
      check_val(it.tag, "B", samp_b, it.eb, tol);
      check_val(it.tag, "C", samp_c, it.ec, tol);
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [39:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  initial begin
    int         first;
    logic [9:0] prev;
    run(3);
    // R1: reset state
    check_eq("R1 reset A", int'(samp_a), 512);
    check_eq("R1 reset B", int'(samp_b), 512);
    check_eq("R1 reset C", int'(samp_c), 512);
    rst_n = 1'b1;
    run(20);

    // R7: shadow writes without update leave outputs at mid-scale
    cur_req = "R7";
    wr(2'd0, F200);
    wr(2'd2, 40'd60);
    wr(2'd1, 40'd0);
    run(30);

    // R2/R3/R5: running sine, three channels
    cur_req = "R2";
    pulse_upd();
    run(250);
    cur_req = "R3";
    run(200);
    cur_req = "R5";
    run(150);

    // R4: phase word and its clamp
    cur_req = "R4";
    wr(2'd1, 40'd900);
    pulse_upd();
    run(220);
    wr(2'd1, 40'd5000);
    pulse_upd();
    run(120);
    wr(2'd1, 40'd0);
    pulse_upd();

    // R6: amplitude scaling, clamp, mute
    cur_req = "R6";
    wr(2'd2, 40'd30);
    pulse_upd();
    run(220);
    wr(2'd2, 40'd99);
    pulse_upd();
    run(220);
    wr(2'd2, 40'd0);
    pulse_upd();
    run(60);

    // R2: negative step wraps backwards
    cur_req = "R2";
    wr(2'd0, 40'hFF_FFFF_FFFF - F200 + 40'd1);
    wr(2'd2, 40'd45);
    pulse_upd();
    run(300);

    // R9: dither on, then off again
    cur_req = "R9";
    wr(2'd3, 40'd1);
    pulse_upd();
    run(400);
    wr(2'd3, 40'd0);
    pulse_upd();
    run(100);

    // R8: frozen phase, then a half-turn phase change; count edges to output
    cur_req = "R8";
    wr(2'd0, 40'd0);
    wr(2'd2, 40'd60);
    pulse_upd();
    run(10);
    wr(2'd1, 40'd1800);
    prev = samp_a;
    upd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    upd = 1'b0;
    first = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (first == 0 && samp_a != prev) first = k;
    end
    check_eq("R8 latency edges", first, 4);
    run(10);
    summary();
  end
endmodule